// File: doc/BRIEF.md
# Burst-Mode DMA Request Sequencer

This block is the front end of a single DMA channel operating in burst mode. It watches an external request line and decides when transfer cycles may run. It emits a start strobe and an acknowledge for each two-clock bus cycle, and counts down a loaded transfer total until the total is used up. The request line can be read in one of two ways. In level mode, the line is checked again before every transfer. In edge mode, a single low-to-high change launches the entire remaining burst.

A non-maskable interrupt input latches a flag. The flag stops the burst at the next point where a new transfer cycle would be issued, and the remaining count is kept. Software clears the flag with a pulse. In edge mode, the channel resumes only on a new rising edge of the request that arrives after the flag has been cleared.

The sequencer has seven states:

- **IDLE**: disabled or finished. It moves to WAIT when enabled with a non-zero count.
- **WAIT**: samples the request every clock. It moves to LEAD1 on a hit while the flag is clear, and back to IDLE when disabled.
- **LEAD1**: always moves to LEAD2.
- **LEAD2**: the second sample in level mode. It moves to XFER_A if the request is still high (or always, in edge mode). It moves to WAIT on a low request or a set flag, and to IDLE when disabled.
- **XFER_A**: always moves to XFER_B.
- **XFER_B**: always moves to GAP.
- **GAP**: the idle clock. It moves to IDLE when the count is zero or the channel is disabled, and to WAIT on a set flag or a low level request. Otherwise it moves to XFER_A.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, bus_start, ack_out, done and nmi_flag are 0 and remaining is 0.
- R2: A load pulse is accepted only in IDLE, where it sets remaining to cnt_value and clears done. A load pulse in any other state leaves remaining unchanged. A zero count never starts a transfer.
- R3: The first bus_start occurs exactly three clocks after the clock in which the request was first sampled as a hit.
- R4: In level mode, the request is sampled a second time two clocks after the first hit. If it is low then, no transfer starts and the channel returns to WAIT.
- R5: In level mode, the request is sampled in the idle clock after each transfer. If it is low, the channel waits and samples every clock, and a new high restarts with the three-clock lead.
- R6: In edge mode, a start needs req_in to be 0 in one clock and 1 in the next. After the start, transfers run back to back until the count is used up, and req_in is ignored.
- R7: Each transfer has bus_start high for its first clock and ack_out high for two clocks, followed by one clock with ack_out low. Transfer starts are 3 clocks apart.
- R8: remaining drops by one per transfer, one clock after the transfer ends. When it reaches zero, done is set and no further transfer starts.
- R9: A rising edge on nmi_in sets nmi_flag, and a nmi_clr pulse clears it. When both occur in the same clock, the set wins.
- R10: With nmi_flag set, no new transfer starts after the current one. The channel returns to WAIT and keeps its remaining count.
- R11: In edge mode, after an abort the channel restarts only on a rising edge that arrives once nmi_flag is clear. Edges seen while the flag is set are discarded.
- R12: If the last transfer completes in the same clock in which nmi_flag becomes set, the channel finishes with done set and remaining at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| edge_mode | input | 1 | 1 = edge-detect requests, 0 = level-detect |
| cnt_load | input | 1 | Load pulse for the transfer count |
| cnt_value | input | CNT_W | Transfer count to load |
| req_in | input | 1 | External transfer request |
| nmi_in | input | 1 | Non-maskable interrupt input |
| nmi_clr | input | 1 | Clear pulse for the interrupt flag |
| bus_start | output | 1 | First clock of a transfer cycle |
| ack_out | output | 1 | Request acknowledge, high through each transfer cycle |
| nmi_flag | output | 1 | Latched interrupt flag |
| done | output | 1 | Count used up |
| remaining | output | CNT_W | Transfers still to run |

## Verification
Three pairs of events can land in the same clock.

- **Last transfer and NMI**: the final transfer's completion and the interrupt flag's setting can coincide. The bench raises nmi_in during the second clock of a single-transfer burst. It then requires done to be set, remaining to be zero, and no later bus_start.
- **Flag set and flag clear**: nmi_in and nmi_clr can both act in one clock. The bench drives both together, and nmi_flag must stay set.
- **Load during suspension**: a load pulse can arrive while an aborted burst waits. The bench sends one, and the preserved count must stay unchanged.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD1,
        ST_LEAD2,
        ST_XFER_A,
        ST_XFER_B,
        ST_GAP
    } burst_state_e;
endpackage

// File: rtl/dreq_sampler.sv
module dreq_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic req_in,
    output logic req_hit
);
    logic req_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= 1'b0;
        else        req_prev <= req_in;
    end

    always_comb begin
        if (edge_mode) req_hit = req_in & ~req_prev;
        else           req_hit = req_in;
    end

    // R6: an edge hit cannot repeat in the following clock
    a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && req_hit) |=> !(edge_mode && req_hit));
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic nmi_clr,
    output logic flag
);
    logic nmi_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_d <= 1'b0;
            flag  <= 1'b0;
        end else begin
            nmi_d <= nmi_in;
            if (nmi_in && !nmi_d) flag <= 1'b1;
            else if (nmi_clr)     flag <= 1'b0;
        end
    end

    // R9: a rising interrupt input always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !nmi_d) |=> flag);
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count <= '0;
        else if (load_en)           count <= load_val;
        else if (dec_en && !is_zero) count <= count - ONE;
    end

    assign is_zero = (count == '0);

    // R8: each transfer lowers the count by exactly one
    a_r8_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load_en && !is_zero) |=> (count == $past(count) - ONE));
    // R2: an exhausted count only changes through a load
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (is_zero && !load_en) |=> is_zero);
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_burst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             edge_mode,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             req_in,
    input  logic             nmi_in,
    input  logic             nmi_clr,
    output logic             bus_start,
    output logic             ack_out,
    output logic             nmi_flag,
    output logic             done,
    output logic [CNT_W-1:0] remaining
);
    burst_state_e state, state_nx;
    logic req_hit, cnt_zero, load_ok, go_on;

    dreq_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode),
        .req_in(req_in), .req_hit(req_hit)
    );

    nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in),
        .nmi_clr(nmi_clr), .flag(nmi_flag)
    );

    assign load_ok = cnt_load && (state == ST_IDLE);

    xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_en(load_ok), .load_val(cnt_value),
        .dec_en(state == ST_XFER_B), .count(remaining), .is_zero(cnt_zero)
    );

    // edge mode keeps going blindly; level mode needs the line high
    assign go_on = edge_mode || req_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (chan_en && !cnt_zero) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!chan_en)                  state_nx = ST_IDLE;
                else if (!nmi_flag && req_hit) state_nx = ST_LEAD1;
            end
            ST_LEAD1:  state_nx = ST_LEAD2;
            ST_LEAD2: begin
                if (!chan_en)      state_nx = ST_IDLE;
                else if (nmi_flag) state_nx = ST_WAIT;
                else if (go_on)    state_nx = ST_XFER_A;
                else               state_nx = ST_WAIT;
            end
            ST_XFER_A: state_nx = ST_XFER_B;
            ST_XFER_B: state_nx = ST_GAP;
            ST_GAP: begin
                if (cnt_zero || !chan_en) state_nx = ST_IDLE;
                else if (nmi_flag)        state_nx = ST_WAIT;
                else if (go_on)           state_nx = ST_XFER_A;
                else                      state_nx = ST_WAIT;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            if (load_ok)                           done <= 1'b0;
            else if (state == ST_GAP && cnt_zero)  done <= 1'b1;
        end
    end

    always_comb begin
        bus_start = (state == ST_XFER_A);
        ack_out   = (state == ST_XFER_A) || (state == ST_XFER_B);
    end

    // R7: the acknowledge spans two clocks from the start strobe
    a_r7_two_clock_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (ack_out && !bus_start));
    // R7: an idle clock follows every transfer
    a_r7_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && !bus_start) |=> !ack_out);
    // R3: a transfer is entered only from the lead-in or the idle clock
    a_r3_lead_in: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> ($past(state) == ST_LEAD2 || $past(state) == ST_GAP));
    // R10: a pending flag blocks the next transfer
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && nmi_flag) |=> !bus_start);
    // R12: completion at the idle clock always raises done
    a_r12_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && cnt_zero) |=> (done && state == ST_IDLE));
    // R8: done implies an exhausted count
    a_r8_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remaining == '0));
endmodule

// File: tb/dma_burst_seq_test.sv
module dma_burst_seq_test;
    localparam int CW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0, edge_mode = 1'b0, cnt_load = 1'b0;
    logic [CW-1:0] cnt_value = '0;
    logic req_in = 1'b0, nmi_in = 1'b0, nmi_clr = 1'b0;
    logic bus_start, ack_out, nmi_flag, done;
    logic [CW-1:0] remaining;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    dma_burst_seq #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .edge_mode(edge_mode),
        .cnt_load(cnt_load), .cnt_value(cnt_value), .req_in(req_in),
        .nmi_in(nmi_in), .nmi_clr(nmi_clr), .bus_start(bus_start),
        .ack_out(ack_out), .nmi_flag(nmi_flag), .done(done), .remaining(remaining)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // bring the channel to WAIT with count n; returns at j = 0
    task automatic arm(input int n, input logic md);
        chan_en = 1'b0; req_in = 1'b0;
        step(); step();
        cnt_value = CW'(n); cnt_load = 1'b1;
        step();
        cnt_load = 1'b0; edge_mode = md; chan_en = 1'b1;
        step();
    endtask

    // full burst sweep, timing computed arithmetically
    task automatic run_burst(input int n, input logic md);
        int dec;
        arm(n, md);
        req_in = 1'b1;
        for (int j = 1; j <= 3*n + 5; j++) begin
            step();
            dec = (j < 5) ? 0 : ((j - 5) / 3 + 1);
            if (dec > n) dec = n;
            chk("R3/R6/R7 bus_start", int'(bus_start),
                int'(j >= 3 && (j-3) % 3 == 0 && (j-3)/3 < n));
            chk("R7 ack_out", int'(ack_out),
                int'(j >= 3 && (j-3) % 3 != 2 && (j-3)/3 < n));
            chk("R8 remaining", int'(remaining), n - dec);
            chk("R8 done", int'(done), int'(j >= 3*n + 3));
            if (md) begin
                // R6: toggling the request during the burst is ignored
                if (j == 1 || j == 7) req_in = 1'b0;
                if (j == 4) req_in = 1'b1;
            end
        end
        req_in = 1'b0;
    endtask

    initial begin
        int hits;
        step(); step();
        // R1 reset state
        chk("R1 bus_start", int'(bus_start), 0);
        chk("R1 ack_out", int'(ack_out), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 nmi_flag", int'(nmi_flag), 0);
        chk("R1 remaining", int'(remaining), 0);
        rst_n = 1'b1;
        step();
        chk("R1 remaining after release", int'(remaining), 0);

        for (int n = 1; n <= 6; n++) run_burst(n, 1'b0);
        for (int n = 1; n <= 6; n++) run_burst(n, 1'b1);

        // R2: zero count never starts
        arm(0, 1'b0);
        req_in = 1'b1;
        hits = 0;
        for (int j = 1; j <= 8; j++) begin
            step();
            hits += int'(ack_out);
        end
        chk("R2 zero count no ack", hits, 0);
        chk("R2 zero count done", int'(done), 0);

        // R4: second level sample low cancels the start
        arm(2, 1'b0);
        req_in = 1'b1;
        step(); step();          // j = 2, LEAD2
        req_in = 1'b0;
        step();                  // j = 3
        chk("R4 no start on low second sample", int'(ack_out), 0);
        req_in = 1'b1;
        step(); chk("R4 lead j4", int'(bus_start), 0);
        step(); chk("R4 lead j5", int'(bus_start), 0);
        step(); chk("R4 restart j6", int'(bus_start), 1);
        step(); step();          // j = 8, GAP
        req_in = 1'b0;
        hits = 0;
        for (int j = 9; j <= 11; j++) begin
            step();
            hits += int'(bus_start);
        end
        chk("R5 low in idle clock stops", hits, 0);
        chk("R5 remaining kept", int'(remaining), 1);
        req_in = 1'b1;           // j = 11
        step(); chk("R5 lead j12", int'(bus_start), 0);
        step(); chk("R5 lead j13", int'(bus_start), 0);
        step(); chk("R5 restart j14", int'(bus_start), 1);
        step(); step(); step();  // j = 17
        chk("R8 done after level restart", int'(done), 1);
        req_in = 1'b0;

        // R10 / R11: interrupt abort and edge restart
        arm(5, 1'b1);
        req_in = 1'b1;
        step(); step(); step(); step();   // j = 4
        nmi_in = 1'b1;
        step();                           // j = 5
        nmi_in = 1'b0;
        step();                           // j = 6
        chk("R9 flag set", int'(nmi_flag), 1);
        chk("R10 no new transfer", int'(ack_out), 0);
        chk("R10 count kept", int'(remaining), 4);
        cnt_value = 24'd99; cnt_load = 1'b1;
        step();                           // j = 7
        cnt_load = 1'b0;
        chk("R2 load ignored outside idle", int'(remaining), 4);
        req_in = 1'b0;
        step();                           // j = 8
        req_in = 1'b1;
        hits = 0;
        for (int j = 9; j <= 12; j++) begin
            step();
            hits += int'(bus_start);
        end
        chk("R11 edge discarded while flag set", hits, 0);
        nmi_clr = 1'b1;
        step();                           // j = 13
        nmi_clr = 1'b0;
        chk("R9 flag cleared", int'(nmi_flag), 0);
        hits = 0;
        for (int j = 14; j <= 17; j++) begin
            step();
            hits += int'(bus_start);
        end
        chk("R11 no restart without fresh edge", hits, 0);
        req_in = 1'b0;
        step();                           // j = 18
        req_in = 1'b1;
        step(); chk("R11 lead j19", int'(bus_start), 0);
        step(); chk("R11 lead j20", int'(bus_start), 0);
        step(); chk("R11 restart j21", int'(bus_start), 1);
        hits = 1;
        for (int j = 22; j <= 35; j++) begin
            step();
            hits += int'(bus_start);
        end
        chk("R10 remaining transfers after resume", hits, 4);
        chk("R8 done after resume", int'(done), 1);
        chk("R8 remaining zero", int'(remaining), 0);
        req_in = 1'b0;

        // R9: set and clear in the same clock, set wins
        nmi_in = 1'b1; nmi_clr = 1'b1;
        step();
        nmi_in = 1'b0;
        chk("R9 set wins over clear", int'(nmi_flag), 1);
        step();
        nmi_clr = 1'b0;
        chk("R9 clear alone", int'(nmi_flag), 0);

        // R12: last transfer completes as the flag rises
        arm(1, 1'b1);
        req_in = 1'b1;
        step(); step(); step(); step();   // j = 4
        nmi_in = 1'b1;
        step();                           // j = 5
        nmi_in = 1'b0;
        step();                           // j = 6
        chk("R12 done wins", int'(done), 1);
        chk("R12 remaining zero", int'(remaining), 0);
        chk("R12 flag still set", int'(nmi_flag), 1);
        hits = 0;
        for (int j = 7; j <= 10; j++) begin
            step();
            hits += int'(bus_start);
        end
        chk("R12 no further transfer", hits, 0);
        nmi_clr = 1'b1;
        step();
        nmi_clr = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule